// File: doc/BRIEF.md
# Sequential Restoring Divider with Integer and Fraction Modes

This block divides an unsigned W-bit dividend by an unsigned W-bit divisor, one quotient bit per clock, using the restoring shift-and-subtract method. A double-width working register holds the partial remainder in its upper half and the unconsumed dividend bits in its lower half. A separate W-bit register collects the quotient bits. Each step shifts the working register left by one bit and compares the upper half, with the bit just shifted out kept as an extra top bit, against the divisor. When the divisor fits, it is subtracted and a 1 enters the quotient. When it does not fit, the shifted value stays as it is and a 0 enters the quotient.

The same control sequence serves two operand formats. In integer mode the dividend fills the lower half of the working register and the result is a whole-number quotient and remainder. In fraction mode the dividend fills the upper half, so the quotient is a binary fraction with its point at the left end. Fraction mode first checks whether the dividend is smaller than the divisor; if it is not, the quotient cannot be a fraction and the block reports overflow. A zero divisor reports overflow in either mode. The caller pulses `start` while the block is idle, waits for the one-cycle `done` pulse, and then reads `quotient`, `remainder` and `overflow`.

Top module: `restoring_div`

## Requirements
- R1: In integer mode (`frac_mode`=0) with a nonzero divisor D and dividend N, the results read at `done` are `quotient` = floor(N/D) and `remainder` = N mod D, with `overflow`=0.
- R2: With W=6, dividing 47 by 5 in integer mode yields `quotient`=9 (001001) and `remainder`=2 (000010).
- R3: In fraction mode (`frac_mode`=1) with N < D, the results read at `done` are `quotient` = floor(N·2^W/D) and `remainder` = (N·2^W) mod D, with `overflow`=0.
- R4: In fraction mode with N >= D and D nonzero, the block does not iterate: `busy` stays 0, `done` is 1 in the cycle after the start edge, `overflow`=1, and `quotient` and `remainder` are both 0.
- R5: A zero divisor in either mode behaves as in R4: no iteration, `done` in the cycle after the start edge, `overflow`=1, and both results 0.
- R6: An accepted start without overflow sets `busy` for exactly W cycles starting in the cycle after the start edge. `done` is 1 for one cycle, in the cycle after `busy` falls.
- R7: A `start` pulse while `busy`=1 is ignored: the running division finishes on its original operands and its original schedule.
- R8: `quotient`, `remainder` and `overflow` keep their values after `done` until the next accepted start. An accepted start without overflow clears `overflow`.
- R9: After a synchronous reset, `busy`, `done`, `overflow`, `quotient` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; accepted only while idle |
| frac_mode | input | 1 | 0 = integer division, 1 = fraction division |
| dividend | input | W | Unsigned dividend, sampled at the start edge |
| divisor | input | W | Unsigned divisor, sampled at the start edge |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| overflow | output | 1 | Set for a zero divisor or a fraction-mode dividend not below the divisor |
| quotient | output | W | Quotient bits; valid from `done` until the next start |
| remainder | output | W | Remainder, upper half of the working register; valid from `done` until the next start |

## Verification
The assertions assume that the operands are sampled only at an accepted start. They also assume that the partial remainder entering every step is already below the divisor. That holds only because integer mode starts from a zero upper half and fraction mode screens out dividends that are not below the divisor. The stimulus therefore holds `start` high for exactly one cycle while idle, except in the deliberate mid-run start. It changes operands only on the falling edge. It also steers fraction-mode random operands to both sides of the N < D boundary, so that the screening is exercised from both sides.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } div_mode_e;
endpackage

// File: rtl/div_step.sv
// One restoring iteration: shift in the next bit, trial-subtract, keep or restore.
module div_step #(
  parameter int W = 6
) (
  input  logic [W-1:0] part_in,
  input  logic         next_bit,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] part_out,
  output logic         q_bit
);
  localparam int WX = W + 1;

  logic [WX-1:0] shifted;
  logic [WX-1:0] trial;

  always_comb begin
    shifted  = {part_in, next_bit};
    trial    = shifted - {1'b0, dvs};
    q_bit    = (shifted >= {1'b0, dvs});
    part_out = q_bit ? trial[W-1:0] : shifted[W-1:0];
  end
endmodule

// File: rtl/div_ctrl.sv
// Sequencer: accepts start while idle, counts W iterations, pulses done.
module div_ctrl #(
  parameter int W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic reject,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] iter_q;
  logic          busy_q;
  logic          done_q;
  logic          last;

  assign load = start & ~busy_q;
  assign step = busy_q;
  assign last = busy_q && (iter_q == CW'(W - 1));
  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      iter_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (load & reject) | last;
      if (load && !reject) begin
        busy_q <= 1'b1;
        iter_q <= '0;
      end else if (busy_q) begin
        iter_q <= iter_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  // R6: done never overlaps an iteration cycle
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);

  // R6: the iteration counter stays within W steps while busy
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (iter_q < CW'(W)));
endmodule

// File: rtl/restoring_div.sv
module restoring_div
  import div_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         frac_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         overflow,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  logic [W-1:0] hi_q, lo_q, quo_q, dvs_q;
  logic         ovf_q;
  logic         load, step, reject;
  logic [W-1:0] hi_next;
  logic         q_bit;
  div_mode_e    mode;

  assign mode   = div_mode_e'(frac_mode);
  assign reject = (divisor == '0) || ((mode == MODE_FRAC) && (dividend >= divisor));

  div_ctrl #(.W(W)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .reject (reject),
    .load   (load),
    .step   (step),
    .busy   (busy),
    .done   (done)
  );

  div_step #(.W(W)) i_step (
    .part_in  (hi_q),
    .next_bit (lo_q[W-1]),
    .dvs      (dvs_q),
    .part_out (hi_next),
    .q_bit    (q_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      ovf_q <= 1'b0;
    end else if (load) begin
      quo_q <= '0;
      dvs_q <= divisor;
      ovf_q <= reject;
      if (reject) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (mode == MODE_FRAC) begin
        hi_q <= dividend;
        lo_q <= '0;
      end else begin
        hi_q <= '0;
        lo_q <= dividend;
      end
    end else if (step) begin
      hi_q  <= hi_next;
      lo_q  <= lo_q << 1;
      quo_q <= {quo_q[W-2:0], q_bit};
    end
  end

  assign quotient  = quo_q;
  assign remainder = hi_q;
  assign overflow  = ovf_q;

  // R1 R3: the partial remainder entering each step is below the divisor
  a_r3_part_below_divisor: assert property (@(posedge clk) disable iff (rst)
    busy |-> (hi_q < dvs_q));

  // R4 R5: an overflowed operation never iterates
  a_r5_no_busy_on_overflow: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !busy);

  // R4: overflow appears together with done
  a_r4_overflow_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> done);

  // R7: a start while busy leaves the captured divisor unchanged
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(dvs_q));
endmodule

// File: tb/test_restoring_div.sv
`timescale 1ns/1ps
module test_restoring_div;
  localparam int W  = 6;
  localparam int NV = 8;
  // {frac_mode, dividend, divisor}
  localparam logic [2*W:0] VEC [NV] = '{
    {1'b0, 6'd47, 6'd5},  {1'b0, 6'd63, 6'd1},  {1'b0, 6'd3, 6'd7},
    {1'b0, 6'd63, 6'd63}, {1'b1, 6'd1, 6'd3},   {1'b1, 6'd62, 6'd63},
    {1'b1, 6'd0, 6'd9},   {1'b1, 6'd5, 6'd8}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, frac_mode = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, overflow;
  logic [W-1:0] quotient, remainder;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  restoring_div #(.W(W)) i_restoring_div (
    .clk(clk), .rst(rst), .start(start), .frac_mode(frac_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .overflow(overflow), .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one division and checks results, latency and busy length.
  task automatic run(input logic m, input int n, input int d, input string req);
    int cyc, busy_cnt, eq, er, eo;
    eo = (d == 0) || (m && n >= d);
    if (eo) begin eq = 0; er = 0; end
    else if (m) begin eq = (n << W) / d; er = (n << W) % d; end
    else begin eq = n / d; er = n % d; end
    @(negedge clk);
    frac_mode = m; dividend = W'(n); divisor = W'(d); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 1; busy_cnt = 0;
    while (!done && cyc < 50) begin
      if (busy) busy_cnt++;
      @(negedge clk);
      cyc++;
    end
    check({req, " quotient"}, int'(quotient), eq);
    check({req, " remainder"}, int'(remainder), er);
    check({req, " overflow"}, int'(overflow), eo);
    check({req, " R6 latency"}, cyc, eo ? 1 : W + 1);
    check({req, " R6 busy cycles"}, busy_cnt, eo ? 0 : W);
  endtask

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 busy", int'(busy), 0);
    check("R9 done", int'(done), 0);
    check("R9 overflow", int'(overflow), 0);
    check("R9 quotient", int'(quotient), 0);
    check("R9 remainder", int'(remainder), 0);

    // Vector table: R1 integer and R3 fraction cases
    for (int i = 0; i < NV; i++)
      run(VEC[i][2*W], int'(VEC[i][2*W-1:W]), int'(VEC[i][W-1:0]),
          VEC[i][2*W] ? "R3" : "R1");

    // R2 worked example
    run(1'b0, 47, 5, "R2");
    check("R2 quotient bits", int'(quotient), 9);
    check("R2 remainder bits", int'(remainder), 2);

    // R4 fraction overflow, boundary N == D and N > D
    run(1'b1, 9, 9, "R4");
    run(1'b1, 40, 3, "R4");
    // R8 overflow cleared by next good start
    run(1'b0, 20, 6, "R8");
    check("R8 overflow cleared", int'(overflow), 0);
    // R5 zero divisor both modes
    run(1'b0, 17, 0, "R5");
    run(1'b1, 0, 0, "R5");

    // R8 results held after done
    run(1'b0, 50, 7, "R8");
    repeat (5) @(negedge clk);
    check("R8 held quotient", int'(quotient), 7);
    check("R8 held remainder", int'(remainder), 1);
    check("R8 held done low", int'(done), 0);

    // R7 start while busy is ignored
    @(negedge clk);
    frac_mode = 1'b0; dividend = 6'd61; divisor = 6'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    dividend = 6'd10; divisor = 6'd0; frac_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int c = 3;
      while (!done && c < 50) begin @(negedge clk); c++; end
      check("R7 latency", c, W + 1);
    end
    check("R7 quotient", int'(quotient), 15);
    check("R7 remainder", int'(remainder), 1);
    check("R7 overflow", int'(overflow), 0);

    // Random operands, both modes
    for (int k = 0; k < 120; k++) begin
      int n = int'($urandom_range(0, 63));
      int d = int'($urandom_range(1, 63));
      logic m = k[0];
      if (m && k[1] && n >= d) n = n % d;
      run(m, n, d, m ? "R3 random" : "R1 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule